// File: doc/BRIEF.md
# Two-Wire Target Byte Memory with Upper-Quarter Write Lock

This block is a two-wire serial bus target in front of an 8 KiB byte store. It samples the bus clock and data lines with the system clock and recognises START and STOP conditions. It answers only to a 7-bit device address that carries a fixed type code and a 3-bit select value, and that select value must equal three board-level strap inputs. Up to eight copies can therefore share one bus.

A write transfer sends the device address, then two bytes that load a 13-bit pointer, then any number of data bytes. A read transfer returns bytes from the pointer. The pointer steps by one after every byte and wraps at the end of the store. A repeated START after the pointer bytes turns a write into a random read. A lock input shields the top quarter of the store from writes without disturbing the bus handshake. The data line is open-drain: the block exposes only a pull-low enable.

Top module: `twi_byte_mem`

## Requirements
- R1: The device byte is sent MSB first as bits [7:4] type code 4'b1010, bits [3:1] select, bit [0] direction (1 = read). The block acknowledges it only when the type code matches and the select bits equal `strap_i`. Otherwise it leaves SDA released and ignores the bus until the next START.
- R2: After a write-direction device byte, the next two bytes set the pointer: bits [4:0] of the first byte become pointer bits [12:8], and the second byte becomes bits [7:0]. Bits [7:5] of the first byte have no effect.
- R3: Every byte the block receives in a selected transfer is acknowledged by pulling SDA low for the ninth SCL pulse.
- R4: In a write transfer, each data byte is stored at the pointer, and the pointer then advances by one.
- R5: In a read transfer, bytes are sent MSB first from the pointer, and the pointer advances by one per byte. A master ACK (SDA low on the ninth pulse) asks for another byte. A master NACK makes the block release SDA and go idle.
- R6: The pointer wraps from 0x1FFF to 0x0000, for both reads and writes.
- R7: While `wp_i` is 1, bytes aimed at 0x1800–0x1FFF leave the store unchanged but are still acknowledged, and the pointer still advances. While `wp_i` is 0, every address is writable.
- R8: A repeated START restarts device-byte decoding and keeps the pointer, so a write of the pointer followed by a repeated START and a read returns data from that pointer.
- R9: STOP returns the block to idle with SDA released.
- R10: Incoming bits are taken on SCL rising edges. `sda_oe_o` changes only while SCL is low, so the block never creates a START or STOP of its own.
- R11: After reset, `sda_oe_o` is 0 and the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, several times faster than SCL |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin (wired level) |
| strap_i | input | 3 | Select value this copy answers to (0 when unconnected) |
| wp_i | input | 1 | 1 locks 0x1800–0x1FFF against writes (0 when unconnected) |
| sda_oe_o | output | 1 | 1 pulls SDA low; 0 releases it |

## Verification
The bench goes after the pointer wrap at 0x1FFF: a design that saturated or dropped a bit there would read back or overwrite the wrong location. It probes the lock boundary at 0x17FF and 0x1800 with the lock on. A design with an off-by-one boundary would corrupt 0x17FF or modify 0x1800, and one that NACKed locked bytes would break the handshake. It sends pointer bytes with junk in the top three bits and device bytes that differ from the straps in one select bit or in the type code, to expose loose address compares. It also ends reads with a NACK to confirm that SDA is let go, and watches that the pull-low enable never moves while SCL is high.

// File: rtl/twi_mem_pkg.sv
package twi_mem_pkg;

    localparam int          MEM_BYTES  = 8192;
    localparam int          ADDR_W     = $clog2(MEM_BYTES);
    localparam int          WORD_BITS  = 64;
    localparam int          STRAP_W    = 3;
    localparam logic [3:0]  DEV_TYPE   = 4'b1010;
    localparam int          LOCK_BITS  = 2;

    typedef logic [ADDR_W-1:0] mem_addr_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RX,
        ST_ACK_SETUP,
        ST_ACK,
        ST_TX,
        ST_MACK
    } bus_state_e;

    typedef enum logic [1:0] {
        ROLE_DEV,
        ROLE_PTR_HI,
        ROLE_PTR_LO,
        ROLE_DATA
    } rx_role_e;

    typedef struct packed {
        logic scl;
        logic sda;
        logic rise;
        logic fall;
        logic start;
        logic stop;
    } line_ev_t;

    function automatic logic dev_match(input logic [7:0] b, input logic [STRAP_W-1:0] strap);
        return (b[7:4] == DEV_TYPE) && (b[3:1] == strap);
    endfunction

    function automatic logic is_locked(input mem_addr_t a, input logic wp);
        return wp && (a[ADDR_W-1 -: LOCK_BITS] == {LOCK_BITS{1'b1}});
    endfunction

endpackage

// File: rtl/twi_line_monitor.sv
module twi_line_monitor
    import twi_mem_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     scl_i,
    input  logic     sda_i,
    output line_ev_t ev
);

    logic [SYNC_STAGES-1:0] scl_sy;
    logic [SYNC_STAGES-1:0] sda_sy;
    logic                   scl_q;
    logic                   sda_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_sy <= '1;
            sda_sy <= '1;
            scl_q  <= 1'b1;
            sda_q  <= 1'b1;
        end else begin
            scl_sy <= {scl_sy[SYNC_STAGES-2:0], scl_i};
            sda_sy <= {sda_sy[SYNC_STAGES-2:0], sda_i};
            scl_q  <= scl_sy[SYNC_STAGES-1];
            sda_q  <= sda_sy[SYNC_STAGES-1];
        end
    end

    always_comb begin
        ev.scl   = scl_sy[SYNC_STAGES-1];
        ev.sda   = sda_sy[SYNC_STAGES-1];
        ev.rise  = ev.scl && !scl_q;
        ev.fall  = !ev.scl && scl_q;
        ev.start = ev.scl && scl_q && sda_q && !ev.sda;
        ev.stop  = ev.scl && scl_q && !sda_q && ev.sda;
    end

endmodule

// File: rtl/twi_mem_array.sv
module twi_mem_array
    import twi_mem_pkg::*;
#(
    parameter int BYTES  = MEM_BYTES,
    parameter int WBITS  = WORD_BITS
) (
    input  logic                     clk,
    input  logic                     we,
    input  logic [$clog2(BYTES)-1:0] waddr,
    input  logic [7:0]               wdata,
    input  logic [$clog2(BYTES)-1:0] raddr,
    output logic [7:0]               rdata
);

    localparam int AW     = $clog2(BYTES);
    localparam int LANES  = WBITS / 8;
    localparam int LANE_W = $clog2(LANES);
    localparam int WORDS  = BYTES / LANES;

    logic [WBITS-1:0] store [WORDS];

    logic [AW-LANE_W-1:0] w_word, r_word;
    logic [LANE_W-1:0]    w_lane, r_lane;

    assign w_word = waddr[AW-1:LANE_W];
    assign w_lane = waddr[LANE_W-1:0];
    assign r_word = raddr[AW-1:LANE_W];
    assign r_lane = raddr[LANE_W-1:0];

    always_ff @(posedge clk) begin
        if (we) begin
            store[w_word][8*int'(w_lane) +: 8] <= wdata;
        end
    end

    assign rdata = store[r_word][8*int'(r_lane) +: 8];

endmodule

// File: rtl/twi_byte_mem.sv
module twi_byte_mem
    import twi_mem_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               scl_i,
    input  logic               sda_i,
    input  logic [STRAP_W-1:0] strap_i,
    input  logic               wp_i,
    output logic               sda_oe_o
);

    line_ev_t   ev;
    bus_state_e state;
    rx_role_e   role;
    logic [3:0] bit_cnt;
    logic [7:0] rx_sh;
    logic [7:0] tx_sh;
    logic [7:0] rx_byte;
    logic [7:0] rd_byte;
    logic       rd_mode;
    logic       sda_low;
    mem_addr_t  ptr;
    logic       adv;
    logic       mem_we;
    mem_addr_t  wr_addr;
    logic [7:0] wr_data;

    twi_line_monitor #(.SYNC_STAGES(SYNC_STAGES)) u_line (
        .clk   (clk),
        .rst   (rst),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .ev    (ev)
    );

    twi_mem_array #(.BYTES(MEM_BYTES), .WBITS(WORD_BITS)) u_mem (
        .clk   (clk),
        .we    (mem_we),
        .waddr (wr_addr),
        .wdata (wr_data),
        .raddr (ptr),
        .rdata (rd_byte)
    );

    assign rx_byte  = {rx_sh[6:0], ev.sda};
    assign sda_oe_o = sda_low;

    always_ff @(posedge clk) begin
        mem_we <= 1'b0;
        adv    <= 1'b0;
        if (rst) begin
            state   <= ST_IDLE;
            role    <= ROLE_DEV;
            bit_cnt <= '0;
            rx_sh   <= '0;
            tx_sh   <= '0;
            rd_mode <= 1'b0;
            sda_low <= 1'b0;
            ptr     <= '0;
            wr_addr <= '0;
            wr_data <= '0;
        end else if (ev.start) begin
            state   <= ST_RX;
            role    <= ROLE_DEV;
            bit_cnt <= '0;
            rd_mode <= 1'b0;
            sda_low <= 1'b0;
        end else if (ev.stop) begin
            state   <= ST_IDLE;
            sda_low <= 1'b0;
        end else begin
            case (state)
                ST_RX: begin
                    if (ev.rise) begin
                        rx_sh <= rx_byte;
                        if (bit_cnt == 4'd7) begin
                            bit_cnt <= '0;
                            state   <= ST_ACK_SETUP;
                            case (role)
                                ROLE_DEV: begin
                                    if (dev_match(rx_byte, strap_i)) begin
                                        rd_mode <= rx_byte[0];
                                        role    <= rx_byte[0] ? ROLE_DATA : ROLE_PTR_HI;
                                    end else begin
                                        state <= ST_IDLE;
                                    end
                                end
                                ROLE_PTR_HI: begin
                                    ptr[ADDR_W-1:8] <= rx_byte[ADDR_W-9:0];
                                    role            <= ROLE_PTR_LO;
                                end
                                ROLE_PTR_LO: begin
                                    ptr[7:0] <= rx_byte;
                                    role     <= ROLE_DATA;
                                end
                                default: begin
                                    mem_we  <= !is_locked(ptr, wp_i);
                                    wr_addr <= ptr;
                                    wr_data <= rx_byte;
                                    ptr     <= ptr + 1'b1;
                                    adv     <= 1'b1;
                                end
                            endcase
                        end else begin
                            bit_cnt <= bit_cnt + 1'b1;
                        end
                    end
                end
                ST_ACK_SETUP: begin
                    if (ev.fall) begin
                        sda_low <= 1'b1;
                        state   <= ST_ACK;
                    end
                end
                ST_ACK: begin
                    if (ev.fall) begin
                        bit_cnt <= '0;
                        if (rd_mode) begin
                            tx_sh   <= rd_byte;
                            sda_low <= !rd_byte[7];
                            ptr     <= ptr + 1'b1;
                            adv     <= 1'b1;
                            state   <= ST_TX;
                        end else begin
                            sda_low <= 1'b0;
                            state   <= ST_RX;
                        end
                    end
                end
                ST_TX: begin
                    if (ev.rise) begin
                        bit_cnt <= bit_cnt + 1'b1;
                    end else if (ev.fall) begin
                        if (bit_cnt == 4'd8) begin
                            sda_low <= 1'b0;
                            state   <= ST_MACK;
                        end else begin
                            tx_sh   <= {tx_sh[6:0], 1'b0};
                            sda_low <= !tx_sh[6];
                        end
                    end
                end
                ST_MACK: begin
                    if (ev.rise && ev.sda) begin
                        state <= ST_IDLE;
                    end else if (ev.fall) begin
                        bit_cnt <= '0;
                        tx_sh   <= rd_byte;
                        sda_low <= !rd_byte[7];
                        ptr     <= ptr + 1'b1;
                        adv     <= 1'b1;
                        state   <= ST_TX;
                    end
                end
                default: ;
            endcase
        end
    end

    // R7: a store write never lands in the locked quarter while the lock is on
    a_r7_lock_blocks_write: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> !is_locked(wr_addr, $past(wp_i)));

    // R6: every advance steps the pointer by exactly one, modulo the store size
    a_r6_pointer_step: assert property (@(posedge clk) disable iff (rst)
        adv |-> ptr == $past(ptr) + 1'b1);

    // R10: the pull-low enable is asserted only when the sampled clock was low
    a_r10_drive_while_low: assert property (@(posedge clk) disable iff (rst)
        $rose(sda_low) |-> !$past(ev.scl));

    // R9: nothing is driven while the block is idle
    a_r9_idle_released: assert property (@(posedge clk) disable iff (rst)
        state == ST_IDLE |-> !sda_low);

    // R1: a device byte with the wrong type code never leads to an acknowledge
    a_r1_reject_type: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RX && role == ROLE_DEV && ev.rise && bit_cnt == 4'd7
         && rx_byte[7:4] != DEV_TYPE) |=> state == ST_IDLE);

endmodule

// File: tb/twi_byte_mem_test.sv
module twi_byte_mem_test;

    localparam int CLK_PERIOD = 10;
    localparam int QTR        = 8;
    localparam int NVEC       = 7;
    // {strap, device byte, expected acknowledge}
    localparam logic [11:0] VEC [NVEC] = '{
        {3'b000, 8'hA0, 1'b1},
        {3'b101, 8'hAA, 1'b1},
        {3'b101, 8'hA2, 1'b0},
        {3'b011, 8'hA6, 1'b1},
        {3'b000, 8'hB0, 1'b0},
        {3'b111, 8'hAE, 1'b1},
        {3'b111, 8'h2E, 1'b0}
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       scl = 1'b1;
    logic       msda = 1'b1;
    logic [2:0] strap = 3'b000;
    logic       wp = 1'b0;
    logic       sda_oe;
    logic       sda_bus;
    int         checks = 0;
    int         fails = 0;
    int         edge_viol = 0;
    logic       oe_prev = 1'b0;
    bit         done = 1'b0;

    assign sda_bus = msda & ~sda_oe;

    always #(CLK_PERIOD/2) clk = ~clk;

    twi_byte_mem uut (
        .clk      (clk),
        .rst      (rst),
        .scl_i    (scl),
        .sda_i    (sda_bus),
        .strap_i  (strap),
        .wp_i     (wp),
        .sda_oe_o (sda_oe)
    );

    // R10 monitor: the enable must not move while SCL is high
    always @(negedge clk) begin
        if (!rst && sda_oe !== oe_prev && scl) edge_viol++;
        oe_prev <= sda_oe;
    end

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        msda = 1'b1; tick(QTR);
        scl = 1'b1;  tick(QTR);
        msda = 1'b0; tick(QTR);
        scl = 1'b0;  tick(QTR);
    endtask

    task automatic bus_stop();
        msda = 1'b0; tick(QTR);
        scl = 1'b1;  tick(QTR);
        msda = 1'b1; tick(2*QTR);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            msda = b[i]; tick(QTR);
            scl = 1'b1;  tick(2*QTR);
            scl = 1'b0;  tick(QTR);
        end
        msda = 1'b1; tick(QTR);
        scl = 1'b1;  tick(QTR);
        ack = !sda_bus;
        tick(QTR);
        scl = 1'b0;  tick(QTR);
    endtask

    task automatic recv_byte(output logic [7:0] d, input logic give_ack);
        msda = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            tick(QTR);
            scl = 1'b1; tick(QTR);
            d[i] = sda_bus;
            tick(QTR);
            scl = 1'b0; tick(QTR);
        end
        msda = give_ack ? 1'b0 : 1'b1; tick(QTR);
        scl = 1'b1; tick(2*QTR);
        scl = 1'b0; tick(QTR);
        msda = 1'b1;
    endtask

    // START, write-direction device byte, two pointer bytes (strap 010)
    task automatic point(input logic [7:0] hi, input logic [7:0] lo, input string req);
        logic a;
        bus_start();
        send_byte(8'hA4, a); chk({req, " dev ack R3"}, a, 1'b1);
        send_byte(hi, a);    chk({req, " ptr hi ack R3"}, a, 1'b1);
        send_byte(lo, a);    chk({req, " ptr lo ack R3"}, a, 1'b1);
    endtask

    task automatic put(input logic [7:0] d, input string req);
        logic a;
        send_byte(d, a);
        chk({req, " data ack"}, a, 1'b1);
    endtask

    // repeated START into a read (strap 010)
    task automatic reread(input string req);
        logic a;
        bus_start();
        send_byte(8'hA5, a);
        chk({req, " read dev ack R8"}, a, 1'b1);
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            report();
        end
    end

    initial begin
        logic       a;
        logic [7:0] d;

        tick(5);
        rst = 1'b0;
        tick(2);
        // R11: released after reset
        chk("R11 reset enable", sda_oe, 1'b0);

        // R1: device select table
        for (int v = 0; v < NVEC; v++) begin
            strap = VEC[v][11:9];
            bus_start();
            send_byte(VEC[v][8:1], a);
            chk($sformatf("R1 select vector %0d", v), a, VEC[v][0]);
            bus_stop();
        end
        strap = 3'b010;

        // R4: sequential write, R8 + R5: random read back
        point(8'h00, 8'h10, "R4");
        put(8'h11, "R4"); put(8'h22, "R4"); put(8'h33, "R4");
        bus_stop();
        point(8'h00, 8'h10, "R8");
        reread("R8");
        recv_byte(d, 1'b1); chk("R5 read byte0", d, 8'h11);
        recv_byte(d, 1'b1); chk("R5 read byte1", d, 8'h22);
        recv_byte(d, 1'b0); chk("R5 read byte2", d, 8'h33);
        tick(QTR);
        chk("R5 released after NACK", sda_oe, 1'b0);
        bus_stop();
        chk("R9 released after STOP", sda_oe, 1'b0);

        // R2: upper pointer bits ignored (0xE0 -> 0x00)
        point(8'hE0, 8'h11, "R2");
        reread("R2");
        recv_byte(d, 1'b0); chk("R2 junk upper bits", d, 8'h22);
        bus_stop();

        // R6: write wraps across 0x1FFF
        point(8'h1F, 8'hFE, "R6");
        put(8'hA1, "R6"); put(8'hB2, "R6"); put(8'hC3, "R6");
        bus_stop();
        point(8'h1F, 8'hFF, "R6");
        reread("R6");
        recv_byte(d, 1'b1); chk("R6 read 0x1FFF", d, 8'hB2);
        recv_byte(d, 1'b0); chk("R6 read wrapped 0x0000", d, 8'hC3);
        bus_stop();

        // R7: lock boundary
        point(8'h17, 8'hFF, "R7");
        put(8'h5A, "R7"); put(8'h6B, "R7");
        bus_stop();
        wp = 1'b1;
        point(8'h17, 8'hFF, "R7");
        put(8'h01, "R7 unlocked"); put(8'h02, "R7 locked");
        bus_stop();
        point(8'h1F, 8'hFF, "R7");
        put(8'h77, "R7 locked top"); put(8'h88, "R7 wrap unlocked");
        bus_stop();
        point(8'h17, 8'hFF, "R7");
        reread("R7");
        recv_byte(d, 1'b1); chk("R7 0x17FF writable", d, 8'h01);
        recv_byte(d, 1'b0); chk("R7 0x1800 kept", d, 8'h6B);
        bus_stop();
        point(8'h1F, 8'hFF, "R7");
        reread("R7");
        recv_byte(d, 1'b1); chk("R7 0x1FFF kept", d, 8'hB2);
        recv_byte(d, 1'b0); chk("R6 pointer advanced past locked byte", d, 8'h88);
        bus_stop();
        wp = 1'b0;
        point(8'h18, 8'h00, "R7");
        put(8'h9C, "R7 unlocked again");
        bus_stop();
        point(8'h18, 8'h00, "R7");
        reread("R7");
        recv_byte(d, 1'b0); chk("R7 lock off writes 0x1800", d, 8'h9C);
        bus_stop();

        // R1: wrong strap ignores the data that follows
        strap = 3'b011;
        bus_start();
        send_byte(8'hA4, a); chk("R1 wrong strap NACK", a, 1'b0);
        send_byte(8'h00, a); chk("R1 ignored after NACK", a, 1'b0);
        bus_stop();
        strap = 3'b010;

        chk("R10 enable stable while SCL high", edge_viol[15:0], 16'd0);

        done = 1'b1;
        report();
    end

endmodule